// File: doc/BRIEF.md
# DRAM row/column address multiplexer

This block drives the external address pins of a programmable DRAM controller, one clock at a time. The upper half of the pin bus always carries the internal access address unchanged. The lower sixteen pins carry one of three things: the column slice of the address (unshifted), the row slice (the address shifted right by 8 to 13 positions), or the low half of a memory address register. The shift comes from a 3-bit mode field. Any pin that the chosen shift leaves without a valid row bit is driven low.

The source for the first clock of an access comes from a single start-select bit. For every later clock until the access ends, it comes from a 2-bit multiplex field in the current microcode word. Outside an access the pins carry the plain address. The pin bus and the configuration error flag are registered, so they reflect the inputs of the previous clock.

Bit naming: pin or address bit An uses big-endian numbering. A0 is the MSB, so An is vector bit [31-n]. The multiplexed pins A16..A31 are therefore pin_addr[15:0].

Top module: `dram_amux`

## Requirements
- R1: While rst is high, pin_addr and config_error are 0 on the following clock.
- R2: Pins A0..A15 (pin_addr[31:16]) equal access_addr[31:16] of the previous clock on every clock.
- R3: On a clock where access_start is 1, pins A16..A31 carry the upper (row) slice if start_upper is 1. If start_upper is 0, they carry access_addr[15:0].
- R4: On later clocks of an access, the field ucode_mux selects the source of pins A16..A31. The codes are 00 = lower, 01 = lower (reserved code), 10 = upper and 11 = mar_value[15:0].
- R5: The row shift is set by row_shift_code as 000=8, 001=9, 010=10, 011=11, 100=12 and 101=13. With the upper slice selected, pin An (n = 16..31) carries internal bit A(n-shift).
- R6: With the upper slice selected, reserved pins are driven 0. These are A16 and A17 (pin_addr[15:14]) for shift 8, and A16 (pin_addr[15]) for shifts 9, 11 and 13. Shifts 10 and 12 have no reserved pin.
- R7: row_shift_code 110 and 111 behave as shift 8 and set config_error to 1 one clock later. All other codes give config_error 0.
- R8: access_start opens an access and takes precedence over access_done on the same clock. access_done ends the access after its own clock, which still uses ucode_mux. With no access open and no start, pins A16..A31 carry access_addr[15:0] whatever ucode_mux holds.
- R9: Every output change appears exactly one clock after the input values that cause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| access_addr | input | 32 | Internal access address |
| mar_value | input | 32 | Memory address register contents |
| row_shift_code | input | 3 | Row shift select from the mode register |
| start_upper | input | 1 | First-clock source select (1 = upper, 0 = lower) |
| ucode_mux | input | 2 | Per-clock multiplex field of the microcode word |
| access_start | input | 1 | Marks the first clock of a new access |
| access_done | input | 1 | Marks the last clock of the current access |
| pin_addr | output | 32 | Registered external address pins |
| config_error | output | 1 | Registered flag for a reserved shift code |

## Verification
The assertions assume that every input is stable and known at each rising edge. They also assume that access_done comes only inside an access or together with a start. The stimulus changes inputs only on falling edges. It issues done only on the last clock of an access or together with a start. It never leaves an input undriven after reset. Reserved shift codes and the reserved microcode value are applied on purpose, because their behaviour is defined.

// File: rtl/dram_amux_pkg.sv
package dram_amux_pkg;

    localparam int ADDR_W    = 32;
    localparam int MUX_W     = 16;
    localparam int CODE_W    = 3;
    localparam int MIN_SHIFT = 8;
    localparam int MAX_CODE  = 5;
    localparam int SHIFT_W   = $clog2(MIN_SHIFT + MAX_CODE + 1);

    typedef enum logic [1:0] {
        UC_LOWER = 2'b00,
        UC_RSVD  = 2'b01,
        UC_UPPER = 2'b10,
        UC_MAR   = 2'b11
    } ucode_mux_e;

    typedef enum logic [1:0] {
        SRC_LOWER,
        SRC_UPPER,
        SRC_MAR
    } pin_src_e;

    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic               bad_code;
    } row_cfg_t;

    function automatic row_cfg_t decode_shift(input logic [CODE_W-1:0] code);
        row_cfg_t c;
        if (int'(code) > MAX_CODE) begin
            c.shift    = SHIFT_W'(MIN_SHIFT);
            c.bad_code = 1'b1;
        end else begin
            c.shift    = SHIFT_W'(MIN_SHIFT + int'(code));
            c.bad_code = 1'b0;
        end
        return c;
    endfunction

    // number of top multiplexed pins that carry no row bit
    function automatic logic [1:0] reserved_count(input logic [SHIFT_W-1:0] shift);
        if (shift == SHIFT_W'(MIN_SHIFT)) return 2'd2;
        else if (shift[0])                return 2'd1;
        else                              return 2'd0;
    endfunction

endpackage

// File: rtl/dram_amux_seq.sv
module dram_amux_seq
    import dram_amux_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       access_start,
    input  logic       access_done,
    input  logic       start_upper,
    input  logic [1:0] ucode_mux,
    output pin_src_e   src,
    output logic       active
);

    ucode_mux_e uc;
    assign uc = ucode_mux_e'(ucode_mux);

    always_ff @(posedge clk) begin
        if (rst)               active <= 1'b0;
        else if (access_start) active <= 1'b1;
        else if (access_done)  active <= 1'b0;
    end

    always_comb begin
        if (access_start) begin
            src = start_upper ? SRC_UPPER : SRC_LOWER;
        end else if (active) begin
            unique case (uc)
                UC_UPPER: src = SRC_UPPER;
                UC_MAR:   src = SRC_MAR;
                default:  src = SRC_LOWER;
            endcase
        end else begin
            src = SRC_LOWER;
        end
    end

endmodule

// File: rtl/dram_amux_row.sv
module dram_amux_row
    import dram_amux_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int MW = MUX_W
) (
    input  logic [AW-1:0]      addr,
    input  logic [SHIFT_W-1:0] shift,
    output logic [MW-1:0]      row
);

    logic [AW-1:0] shifted;
    logic [1:0]    n_rsv;

    always_comb begin
        shifted = addr >> shift;
        n_rsv   = reserved_count(shift);
    end

    for (genvar j = 0; j < MW; j++) begin : g_pin
        localparam int DEPTH = MW - 1 - j;
        assign row[j] = (DEPTH < int'(n_rsv)) ? 1'b0 : shifted[j];
    end

endmodule

// File: rtl/dram_amux.sv
module dram_amux
    import dram_amux_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int MW = MUX_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] access_addr,
    input  logic [AW-1:0] mar_value,
    input  logic [CW-1:0] row_shift_code,
    input  logic          start_upper,
    input  logic [1:0]    ucode_mux,
    input  logic          access_start,
    input  logic          access_done,
    output logic [AW-1:0] pin_addr,
    output logic          config_error
);

    pin_src_e      src;
    logic          active;
    row_cfg_t      cfg;
    logic [MW-1:0] row_bits;
    logic [MW-1:0] low_next;

    assign cfg = decode_shift(row_shift_code);

    dram_amux_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .access_start (access_start),
        .access_done  (access_done),
        .start_upper  (start_upper),
        .ucode_mux    (ucode_mux),
        .src          (src),
        .active       (active)
    );

    dram_amux_row #(.AW(AW), .MW(MW)) u_row (
        .addr  (access_addr),
        .shift (cfg.shift),
        .row   (row_bits)
    );

    always_comb begin
        unique case (src)
            SRC_UPPER: low_next = row_bits;
            SRC_MAR:   low_next = mar_value[MW-1:0];
            default:   low_next = access_addr[MW-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_addr     <= '0;
            config_error <= 1'b0;
        end else begin
            pin_addr     <= {access_addr[AW-1:MW], low_next};
            config_error <= cfg.bad_code;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pin_addr == '0 && !config_error));

    // R2
    upper_pass_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pin_addr[AW-1:MW] == $past(access_addr[AW-1:MW]));

    // R3
    start_lower_chk: assert property (@(posedge clk) disable iff (rst)
        (access_start && !start_upper) |=> pin_addr[MW-1:0] == $past(access_addr[MW-1:0]));

    // R4
    mar_path_chk: assert property (@(posedge clk) disable iff (rst)
        (!access_start && active && ucode_mux == 2'b11) |=> pin_addr[MW-1:0] == $past(mar_value[MW-1:0]));

    // R6
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (access_start && start_upper && row_shift_code == 3'b000) |=> pin_addr[MW-1:MW-2] == 2'b00);

    // R7
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
        (row_shift_code > 3'd5) |=> config_error);

    // R8
    idle_lower_chk: assert property (@(posedge clk) disable iff (rst)
        (!access_start && !active) |=> pin_addr[MW-1:0] == $past(access_addr[MW-1:0]));

endmodule

// File: tb/tb_dram_amux.sv
module tb_dram_amux;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] access_addr, mar_value;
    logic [2:0]  row_shift_code;
    logic        start_upper, access_start, access_done;
    logic [1:0]  ucode_mux;
    logic [31:0] pin_addr;
    logic        config_error;

    int errors = 0;
    int checks = 0;
    bit model_active = 0;

    always #10 clk = ~clk;

    dram_amux dut (
        .clk(clk), .rst(rst), .access_addr(access_addr), .mar_value(mar_value),
        .row_shift_code(row_shift_code), .start_upper(start_upper),
        .ucode_mux(ucode_mux), .access_start(access_start), .access_done(access_done),
        .pin_addr(pin_addr), .config_error(config_error)
    );

    function automatic bit is_reserved(int n, int s);
        if (s == 8 && (n == 16 || n == 17)) return 1;
        if ((s == 9 || s == 11 || s == 13) && n == 16) return 1;
        return 0;
    endfunction

    // src: 0 lower, 1 upper, 2 mar
    function automatic logic [31:0] ref_pins(int src, logic [31:0] a, logic [31:0] m, int code);
        logic [31:0] r;
        int s;
        s = (code <= 5) ? 8 + code : 8;
        r = a;
        for (int n = 16; n < 32; n++) begin
            if (src == 2) r[31-n] = m[31-n];
            else if (src == 1) r[31-n] = is_reserved(n, s) ? 1'b0 : a[31-(n-s)];
            else r[31-n] = a[31-n];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one clock of stimulus, then compare at the next falling edge
    task automatic step(bit st, bit dn, bit su, int uc, int code, logic [31:0] a, logic [31:0] m);
        int src;
        string tag;
        logic [31:0] exp;
        access_start = st; access_done = dn; start_upper = su;
        ucode_mux = 2'(uc); row_shift_code = 3'(code);
        access_addr = a; mar_value = m;
        if (st) begin
            src = su ? 1 : 0; tag = "R3";
        end else if (model_active) begin
            src = (uc == 2) ? 1 : (uc == 3) ? 2 : 0; tag = "R4 R8";
        end else begin
            src = 0; tag = "R8";
        end
        if (src == 1) tag = {tag, " R5 R6"};
        if (st) model_active = 1;
        else if (dn) model_active = 0;
        exp = ref_pins(src, a, m, code);
        @(negedge clk);
        check("R2 R9 upper pins", {16'h0, pin_addr[31:16]}, {16'h0, exp[31:16]});
        check({tag, " R9 lower pins"}, {16'h0, pin_addr[15:0]}, {16'h0, exp[15:0]});
        check("R7 config_error", {31'h0, config_error}, {31'h0, (code > 5)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1; access_start = 0; access_done = 0; start_upper = 0;
        ucode_mux = 0; row_shift_code = 0;
        access_addr = 32'hDEADBEEF; mar_value = 32'h12345678;
        repeat (3) @(negedge clk);
        check("R1 reset pins", pin_addr, 32'h0);
        check("R1 reset error", {31'h0, config_error}, 32'h0);
        rst = 0;

        // every shift code with first-clock upper, then all microcode values
        for (int code = 0; code < 8; code++) begin
            step(1, 0, 1, 0, code, $urandom, $urandom);
            step(0, 0, 0, 2, code, 32'hFFFF_FFFF, $urandom);
            step(0, 0, 0, 3, code, $urandom, $urandom);
            step(0, 0, 0, 0, code, $urandom, $urandom);
            step(0, 0, 0, 1, code, $urandom, $urandom);
            step(0, 1, 0, 2, code, $urandom, $urandom);
            step(0, 0, 0, 2, code, $urandom, $urandom);  // idle: ignored
            step(0, 0, 0, 3, code, $urandom, $urandom);  // idle: ignored
        end

        // first clock lower, then start and done together
        step(1, 0, 0, 2, 2, $urandom, $urandom);
        step(0, 1, 0, 2, 2, $urandom, $urandom);
        step(1, 1, 1, 0, 4, $urandom, $urandom);
        step(0, 0, 0, 2, 4, $urandom, $urandom);
        step(0, 1, 0, 3, 4, $urandom, $urandom);
        step(0, 0, 0, 3, 4, $urandom, $urandom);

        // random legal traffic
        for (int i = 0; i < 400; i++) begin
            bit st, dn;
            st = ($urandom % 5) == 0;
            dn = model_active && (($urandom % 4) == 0);
            step(st, dn, 1'($urandom), int'($urandom % 4), int'($urandom % 8), $urandom, $urandom);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule